// File: doc/BRIEF.md
# Floating-Point Branch Resolution Unit

This block settles the outcome of a floating-point conditional branch in a pipeline that uses delayed branches. It tracks three program counters: the current one, the one after it (the delay slot) and the one after that. From the branch's 4-bit test code it decides whether the branch is taken. The four-state condition code it tests (equal, less, greater, unordered) is picked from the floating-point status word. The block then produces the updated pair of following PCs, and it also reports whether the delay slot is to be skipped.

Two instruction forms are served. The versioned form has a 19-bit word displacement and can test any of four condition-code sets. The legacy form has a 22-bit word displacement and always tests set 0. A request is accepted with `in_valid`. Its result appears registered one clock later, qualified by `out_valid`.

Top module: `fpbr_unit`

## Requirements
- R1: The condition code tested is a 2-bit field of `fp_status`, encoded 0 = equal, 1 = less, 2 = greater, 3 = unordered. In the versioned form (`form_ver` = 1), `cc_set` picks the field: set 0 is bits [11:10], set 1 is [33:32], set 2 is [35:34] and set 3 is [37:36]. In the legacy form (`form_ver` = 0), bits [11:10] are always used and `cc_set` is ignored.
- R2: The branch passes when the condition code is one of the codes that `test_code` accepts:
  - 0x0 accepts none and 0x8 accepts all.
  - 0x1 accepts less, greater and unordered. 0x2 accepts less and greater.
  - 0x3 accepts unordered and less. 0x4 accepts less. 0x5 accepts unordered and greater.
  - 0x6 accepts greater. 0x7 accepts unordered. 0x9 accepts equal.
  - 0xA accepts unordered and equal. 0xB accepts greater and equal.
  - 0xC accepts unordered, greater and equal. 0xD accepts less and equal.
  - 0xE accepts unordered, less and equal. 0xF accepts equal, less and greater.
- R3: The byte offset is the word displacement, sign-extended and multiplied by 4. The versioned form uses `disp_field`[18:0] with bit 18 as the sign and ignores bits [21:19]. The legacy form uses all 22 bits.
- R4: A passing conditional test (any code except 0x0 and 0x8) gives `taken` = 1 and `annul_slot` = 0. It sets the next-next PC to `pc_cur` + offset and keeps the next PC equal to `pc_next`, whatever the annul bit is.
- R5: A failing test with `annul` = 0 gives `taken` = 0 and `annul_slot` = 0, and both output PCs equal the input `pc_next` and `pc_next2`.
- R6: A failing test with `annul` = 1 gives `taken` = 0 and `annul_slot` = 1, with next PC = `pc_next` + 4 and next-next PC = `pc_next` + 8.
- R7: Test code 0x8 with `annul` = 0 gives `taken` = 1 and `annul_slot` = 0, next PC = `pc_next` and next-next PC = `pc_cur` + offset.
- R8: Test code 0x8 with `annul` = 1 gives `taken` = 1 and `annul_slot` = 1, next PC = `pc_cur` + offset and next-next PC = `pc_cur` + offset + 4.
- R9: Test code 0x0 is never taken. With `annul` = 0 it changes nothing; with `annul` = 1 it skips the slot in the same way as R6.
- R10: A request accepted on a clock edge shows `out_valid` = 1 with its result after that edge. When `in_valid` is 0 at an edge, `out_valid` is 0 afterwards and the other outputs hold their previous values.
- R11: A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| test_code | input | 4 | Branch condition test code |
| annul | input | 1 | Annul bit of the branch |
| form_ver | input | 1 | 1 = versioned form, 0 = legacy form |
| cc_set | input | 2 | Condition-code set choice (versioned form) |
| disp_field | input | 22 | Raw word displacement field |
| fp_status | input | 64 | Floating-point status word |
| pc_cur | input | 64 | PC of the branch |
| pc_next | input | 64 | Next PC (delay slot) |
| pc_next2 | input | 64 | Next-next PC |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| annul_slot | output | 1 | Delay slot is skipped |
| pc_next_o | output | 64 | Updated next PC |
| pc_next2_o | output | 64 | Updated next-next PC |

## Verification
The assertions check the following on every cycle:
- the valid timing;
- that a skipped slot always leaves the two output PCs 4 apart;
- that a not-taken, non-annulled result and a taken conditional result keep the incoming next PC;
- that test codes 0x0 and 0x8 resolve to never and always;
- that the per-set condition decode is one-hot.

Only the bench's scenarios can show that the right status-word field is picked for each set and form. The same holds for the full test-code table across all four condition codes, the sign-extension boundaries of both displacement widths, and the exact target arithmetic.

// File: rtl/fpbr_pkg.sv
package fpbr_pkg;

    localparam int PC_W = 64;

    typedef enum logic [1:0] {
        FCC_EQ = 2'd0,
        FCC_LT = 2'd1,
        FCC_GT = 2'd2,
        FCC_UN = 2'd3
    } fcc_e;

    typedef enum logic [3:0] {
        TST_NEVER  = 4'h0,
        TST_NE     = 4'h1,
        TST_LG     = 4'h2,
        TST_UL     = 4'h3,
        TST_L      = 4'h4,
        TST_UG     = 4'h5,
        TST_G      = 4'h6,
        TST_U      = 4'h7,
        TST_ALWAYS = 4'h8,
        TST_E      = 4'h9,
        TST_UE     = 4'hA,
        TST_GE     = 4'hB,
        TST_UGE    = 4'hC,
        TST_LE     = 4'hD,
        TST_ULE    = 4'hE,
        TST_ORD    = 4'hF
    } test_e;

    // accept mask bit order: {unordered, greater, less, equal}
    typedef logic [3:0] accept_t;

    typedef struct packed {
        logic            valid;
        logic            taken;
        logic            annul_slot;
        logic [PC_W-1:0] pc_next;
        logic [PC_W-1:0] pc_next2;
    } result_t;

endpackage

// File: rtl/fpbr_cc_select.sv
module fpbr_cc_select #(
    parameter int STAT_W   = 64,
    parameter int NUM_SETS = 4,
    parameter int BASE0_LO = 10,
    parameter int BASE1_LO = 32
) (
    input  logic [STAT_W-1:0]           fp_status,
    input  logic                        form_ver,
    input  logic [$clog2(NUM_SETS)-1:0] cc_set,
    output logic [1:0]                  cc
);
    logic [1:0] fields [NUM_SETS];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SETS; gi++) begin : g_field
            localparam int LO = (gi == 0) ? BASE0_LO : BASE1_LO + 2 * (gi - 1);
            assign fields[gi] = fp_status[LO+1:LO];
        end
    endgenerate

    logic unused_status;
    assign unused_status = ^fp_status;

    always_comb begin
        if (form_ver) cc = fields[cc_set];
        else          cc = fields[0];
    end
endmodule

// File: rtl/fpbr_cond_eval.sv
module fpbr_cond_eval
    import fpbr_pkg::*;
(
    input  logic [3:0] test_code,
    input  logic [1:0] cc,
    output logic       pass,
    output logic       is_always
);
    accept_t mask;
    accept_t hit;

    always_comb begin
        unique case (test_e'(test_code))
            TST_NEVER:  mask = 4'b0000;
            TST_ALWAYS: mask = 4'b1111;
            TST_U:      mask = 4'b1000;
            TST_G:      mask = 4'b0100;
            TST_UG:     mask = 4'b1100;
            TST_L:      mask = 4'b0010;
            TST_UL:     mask = 4'b1010;
            TST_LG:     mask = 4'b0110;
            TST_NE:     mask = 4'b1110;
            TST_E:      mask = 4'b0001;
            TST_UE:     mask = 4'b1001;
            TST_GE:     mask = 4'b0101;
            TST_UGE:    mask = 4'b1101;
            TST_LE:     mask = 4'b0011;
            TST_ULE:    mask = 4'b1011;
            TST_ORD:    mask = 4'b0111;
            default:    mask = 4'b0000;
        endcase
    end

    always_comb begin
        hit = '0;
        unique case (fcc_e'(cc))
            FCC_EQ:  hit[0] = 1'b1;
            FCC_LT:  hit[1] = 1'b1;
            FCC_GT:  hit[2] = 1'b1;
            FCC_UN:  hit[3] = 1'b1;
            default: hit = '0;
        endcase
    end

    assign pass      = |(mask & hit);
    assign is_always = (test_code == TST_ALWAYS);

    // R1: exactly one of the four condition states is decoded
    always_comb begin
        a_cc_onehot_r1: assert ($countones(hit) == 1 || $isunknown(cc));
    end
endmodule

// File: rtl/fpbr_pc_update.sv
module fpbr_pc_update #(
    parameter int PC_W   = 64,
    parameter int DISP_W = 22,
    parameter int VDSP_W = 19
) (
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [PC_W-1:0]   pc_next,
    input  logic [PC_W-1:0]   pc_next2,
    input  logic [DISP_W-1:0] disp_field,
    input  logic              form_ver,
    input  logic              annul,
    input  logic              pass,
    input  logic              is_always,
    output logic              taken,
    output logic              annul_slot,
    output logic [PC_W-1:0]   pc_next_n,
    output logic [PC_W-1:0]   pc_next2_n
);
    localparam int LEG_PAD = PC_W - DISP_W - 2;
    localparam int VER_PAD = PC_W - VDSP_W - 2;

    logic [PC_W-1:0] off_leg, off_ver, offset, target;

    assign off_leg = {{LEG_PAD{disp_field[DISP_W-1]}}, disp_field, 2'b00};
    assign off_ver = {{VER_PAD{disp_field[VDSP_W-1]}}, disp_field[VDSP_W-1:0], 2'b00};
    assign offset  = form_ver ? off_ver : off_leg;
    assign target  = pc_cur + offset;

    always_comb begin
        taken      = 1'b0;
        annul_slot = 1'b0;
        pc_next_n  = pc_next;
        pc_next2_n = pc_next2;
        if (is_always) begin
            taken = 1'b1;
            if (annul) begin
                annul_slot = 1'b1;
                pc_next_n  = target;
                pc_next2_n = target + PC_W'(4);
            end else begin
                pc_next2_n = target;
            end
        end else if (pass) begin
            taken      = 1'b1;
            pc_next2_n = target;
        end else if (annul) begin
            annul_slot = 1'b1;
            pc_next_n  = pc_next + PC_W'(4);
            pc_next2_n = pc_next + PC_W'(8);
        end
    end
endmodule

// File: rtl/fpbr_unit.sv
module fpbr_unit
    import fpbr_pkg::*;
#(
    parameter int STAT_W = 64,
    parameter int DISP_W = 22,
    parameter int VDSP_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        test_code,
    input  logic              annul,
    input  logic              form_ver,
    input  logic [1:0]        cc_set,
    input  logic [DISP_W-1:0] disp_field,
    input  logic [STAT_W-1:0] fp_status,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [PC_W-1:0]   pc_next,
    input  logic [PC_W-1:0]   pc_next2,
    output logic              out_valid,
    output logic              taken,
    output logic              annul_slot,
    output logic [PC_W-1:0]   pc_next_o,
    output logic [PC_W-1:0]   pc_next2_o
);
    logic [1:0]      cc;
    logic            pass, is_always, taken_c, slot_c;
    logic [PC_W-1:0] pn_c, pn2_c;
    result_t         st_d, st_q;

    fpbr_cc_select #(.STAT_W(STAT_W), .NUM_SETS(4)) u_sel (
        .fp_status(fp_status), .form_ver(form_ver), .cc_set(cc_set), .cc(cc)
    );

    fpbr_cond_eval u_eval (
        .test_code(test_code), .cc(cc), .pass(pass), .is_always(is_always)
    );

    fpbr_pc_update #(.PC_W(PC_W), .DISP_W(DISP_W), .VDSP_W(VDSP_W)) u_upd (
        .pc_cur(pc_cur), .pc_next(pc_next), .pc_next2(pc_next2),
        .disp_field(disp_field), .form_ver(form_ver), .annul(annul),
        .pass(pass), .is_always(is_always), .taken(taken_c),
        .annul_slot(slot_c), .pc_next_n(pn_c), .pc_next2_n(pn2_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.taken      = taken_c;
            st_d.annul_slot = slot_c;
            st_d.pc_next    = pn_c;
            st_d.pc_next2   = pn2_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign taken      = st_q.taken;
    assign annul_slot = st_q.annul_slot;
    assign pc_next_o  = st_q.pc_next;
    assign pc_next2_o = st_q.pc_next2;

    p_accept_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(pc_next_o) && $stable(pc_next2_o));
    p_skip_gap_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && annul_slot |-> pc_next2_o == pc_next_o + PC_W'(4));
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid && !taken_c && !slot_c |=> pc_next_o == $past(pc_next) && pc_next2_o == $past(pc_next2));
    p_keep_slot_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid && pass && !is_always |=> taken && !annul_slot && pc_next_o == $past(pc_next));
    p_never_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid && test_code == 4'h0 |=> !taken);
    p_always_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && test_code == 4'h8 |=> taken);
endmodule

// File: tb/fpbr_unit_tb.sv
`timescale 1ns/1ps
module fpbr_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  test_code = '0;
    logic        annul = 1'b0;
    logic        form_ver = 1'b0;
    logic [1:0]  cc_set = '0;
    logic [21:0] disp_field = '0;
    logic [63:0] fp_status = '0;
    logic [63:0] pc_cur = '0, pc_next = '0, pc_next2 = '0;
    logic        out_valid, taken, annul_slot;
    logic [63:0] pc_next_o, pc_next2_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit          e_taken, e_slot;
    logic [63:0] e_pn, e_pn2;

    always #4 clk = ~clk;

    fpbr_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .test_code(test_code),
        .annul(annul), .form_ver(form_ver), .cc_set(cc_set),
        .disp_field(disp_field), .fp_status(fp_status), .pc_cur(pc_cur),
        .pc_next(pc_next), .pc_next2(pc_next2), .out_valid(out_valid),
        .taken(taken), .annul_slot(annul_slot), .pc_next_o(pc_next_o),
        .pc_next2_o(pc_next2_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit ref_pass(input logic [1:0] cc, input logic [3:0] c);
        bit e, l, g, u;
        e = (cc == 2'd0); l = (cc == 2'd1); g = (cc == 2'd2); u = (cc == 2'd3);
        case (c)
            4'h0: return 0;
            4'h8: return 1;
            4'h7: return u;
            4'h6: return g;
            4'h5: return u || g;
            4'h4: return l;
            4'h3: return u || l;
            4'h2: return l || g;
            4'h1: return l || g || u;
            4'h9: return e;
            4'hA: return u || e;
            4'hB: return g || e;
            4'hC: return u || g || e;
            4'hD: return l || e;
            4'hE: return u || l || e;
            default: return e || l || g;
        endcase
    endfunction

    // compute expectation from current inputs, clock once, compare
    task automatic send(input logic [3:0] c, input bit a, input bit ver,
                        input logic [1:0] set, input logic [21:0] d,
                        input logic [63:0] st, input logic [63:0] p,
                        input logic [63:0] pn, input logic [63:0] pn2,
                        input string extra);
        logic [1:0]  cc;
        logic [63:0] off, tgt;
        bit          ok;
        string       tag;
        in_valid = 1; test_code = c; annul = a; form_ver = ver; cc_set = set;
        disp_field = d; fp_status = st; pc_cur = p; pc_next = pn; pc_next2 = pn2;
        if (!ver) cc = st[11:10];
        else case (set)
            2'd0: cc = st[11:10];
            2'd1: cc = st[33:32];
            2'd2: cc = st[35:34];
            default: cc = st[37:36];
        endcase
        if (ver) off = 64'($signed(d[18:0])) * 4;
        else     off = 64'($signed(d)) * 4;
        tgt = p + off;
        ok = ref_pass(cc, c);
        if (c == 4'h8) begin
            e_taken = 1; e_slot = a;
            e_pn  = a ? tgt : pn;
            e_pn2 = a ? tgt + 4 : tgt;
            tag = a ? "R8" : "R7";
        end else if (ok) begin
            e_taken = 1; e_slot = 0; e_pn = pn; e_pn2 = tgt; tag = "R4";
        end else begin
            e_taken = 0; e_slot = a;
            e_pn  = a ? pn + 4 : pn;
            e_pn2 = a ? pn + 8 : pn2;
            tag = (c == 4'h0) ? "R9" : (a ? "R6" : "R5");
        end
        if (extra != "") tag = {tag, "/", extra};
        @(negedge clk);
        chk(out_valid == 1'b1, "R10", "out_valid", 64'(out_valid), 64'd1);
        chk(taken == e_taken, tag, "taken", 64'(taken), 64'(e_taken));
        chk(annul_slot == e_slot, tag, "annul_slot", 64'(annul_slot), 64'(e_slot));
        chk(pc_next_o == e_pn, tag, "pc_next_o", pc_next_o, e_pn);
        chk(pc_next2_o == e_pn2, tag, "pc_next2_o", pc_next2_o, e_pn2);
    endtask

    task automatic idle();
        in_valid = 0; test_code = 4'($urandom); annul = 1'($urandom);
        pc_next = {$urandom, $urandom};
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "idle out_valid", 64'(out_valid), 64'd0);
        chk(pc_next_o == e_pn && pc_next2_o == e_pn2, "R10", "hold pc_next_o",
            pc_next_o, e_pn);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] st;
        in_valid = 1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R11", "reset out_valid", 64'(out_valid), 64'd0);
        rst = 0; in_valid = 0;
        @(negedge clk);

        // R1: distinct code in each field: set0 eq, set1 less, set2 greater, set3 unordered
        st = 64'd0;
        st[11:10] = 2'd0; st[33:32] = 2'd1; st[35:34] = 2'd2; st[37:36] = 2'd3;
        send(4'h9, 0, 1, 2'd0, 22'd5, st, 64'h1000, 64'h1004, 64'h1008, "R1 set0");
        send(4'h4, 0, 1, 2'd1, 22'd5, st, 64'h1000, 64'h1004, 64'h1008, "R1 set1");
        send(4'h6, 0, 1, 2'd2, 22'd5, st, 64'h1000, 64'h1004, 64'h1008, "R1 set2");
        send(4'h7, 1, 1, 2'd3, 22'd5, st, 64'h1000, 64'h1004, 64'h1008, "R1 set3");
        send(4'h9, 0, 0, 2'd3, 22'd5, st, 64'h1000, 64'h1004, 64'h1008, "R1 legacy");
        send(4'h7, 1, 0, 2'd3, 22'd5, st, 64'h1000, 64'h1004, 64'h1008, "R1 legacy");

        // R2: every test code against every condition code
        for (int c = 0; c < 16; c++)
            for (int v = 0; v < 4; v++)
                send(4'(c), 1'(v), 0, 2'd0, 22'd16, {52'd0, 2'(v), 10'd0},
                     64'h2000, 64'h2004, 64'h2008, "R2");

        // R3: displacement widths and signs
        send(4'h8, 0, 1, 2'd0, 22'h3C0001, 64'd0, 64'h4000, 64'h4004, 64'h4008, "R3 upper ignored");
        send(4'h8, 0, 1, 2'd0, 22'h040000, 64'd0, 64'h100000, 64'h100004, 64'h100008, "R3 ver neg");
        send(4'h8, 1, 0, 2'd0, 22'h200000, 64'd0, 64'h1000000, 64'h1000004, 64'h1000008, "R3 leg neg");
        send(4'h8, 1, 0, 2'd0, 22'h1FFFFF, 64'd0, 64'h10, 64'h14, 64'h18, "R3 leg max");
        idle();
        idle();

        // reset with a pending request
        in_valid = 1;
        rst = 1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11", "mid reset out_valid", 64'(out_valid), 64'd0);
        rst = 0;
        in_valid = 0;
        @(negedge clk);

        for (int i = 0; i < 3000; i++) begin
            send(4'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                 22'($urandom), rnd64(), rnd64(), rnd64(), rnd64(), "");
            if (($urandom % 5) == 0) idle();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule